// File: doc/BRIEF.md
# Configurable 54-bit Accumulating Adder

This block adds, subtracts and accumulates two 54-bit operands. It can also take a 55-bit cascade term from a neighbouring unit. Static parameters fix its shape at elaboration:

- the datapath mode;
- the add or subtract sense of the B operand, and of the A operand in mode 0;
- whether each operand, each sign flag and the load control is captured in a register or passed straight through;
- whether the result is registered;
- whether reset acts synchronously or asynchronously.

A per-cycle load control picks the feedback term. When load is high, the feedback term is the running accumulator. When load is low, the feedback term is zero, which starts a new sum.

The full 55-bit internal sum leaves on the cascade output, so units can be chained. The 54-bit result is the lower part of that sum. All arithmetic wraps modulo 2^55.

Top module: `acc54_unit`

## Requirements
- R1: While reset is high, every register is cleared, so a unit with a registered output shows zero on `dout` and `casOut` at the first clock edge after reset.
- R2: With `MODE`=0, the new sum is F ± B ± A. F is the feedback term. `B_SUB`=1 negates the B term and `SECOND_SUB`=1 negates the A term; a value of 0 adds the term.
- R3: With `MODE`=1, the new sum is F ± B + `casIn`, where the sense of B is chosen by `B_SUB`.
- R4: With `MODE`=2, the new sum is A ± B + `casIn`. `accLoad` has no effect on the result.
- R5: The feedback term F is the accumulator when the (possibly registered) `accLoad` is 1, and zero when it is 0.
- R6: An operand whose sign flag is 1 is sign-extended to 55 bits before the addition; with the flag at 0 it is zero-extended.
- R7: While `ce` is 0, every register holds, including the input capture registers and the accumulator, so a registered output stays constant.
- R8: Each input parameter set to 1 adds one clock of capture before the adder. `OUT_REG_EN`=1 presents the accumulator one edge after the sum is formed; `OUT_REG_EN`=0 presents the sum combinationally.
- R9: With `ASYNC_RST`=1, raising `rst` clears the registers at once, without waiting for a clock edge. With `ASYNC_RST`=0, the clear takes effect at the next rising edge.
- R10: `casOut` carries the full 55-bit wrapped sum, and `dout` equals `casOut[53:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Active-high reset, synchronous or asynchronous per `ASYNC_RST` |
| ce | input | 1 | Clock enable for every register |
| aIn | input | 54 | Operand A |
| bIn | input | 54 | Operand B |
| casIn | input | 55 | Cascade term from a neighbouring unit |
| aSigned | input | 1 | 1: A is signed, 0: A is unsigned |
| bSigned | input | 1 | 1: B is signed, 0: B is unsigned |
| accLoad | input | 1 | 1: feed the accumulator back, 0: feed back zero |
| dout | output | 54 | Lower 54 bits of the sum |
| casOut | output | 55 | Full 55-bit sum toward the next unit |

## Verification
Some properties are checked by the assertions on every clock:

- the register clear that follows reset;
- the hold of a registered output while the enable is low;
- for variants whose inputs are not registered, the per-mode sum recurrence, including the accumulator feedback and the add or subtract sense.

The bench's scenarios cover what a per-cycle property cannot reach:

- the extra capture cycle of registered inputs;
- the asynchronous clear that lands between clock edges, compared against a synchronous unit that keeps its value;
- sign versus zero extension of an all-ones operand;
- load-controlled restarts of the running sum;
- wrap-around behaviour over long random runs on four differently configured instances.

// File: rtl/acc54_pkg.sv
package acc54_pkg;

  // Strobes from control to datapath, already aligned to the operand stage
  typedef struct packed {
    logic aSigned;
    logic bSigned;
    logic useFeedback;
  } ctrlStrobes_t;

endpackage

// File: rtl/acc54_stage.sv
// One optional capture stage: registered or pass-through, chosen reset style
module acc54_stage #(
  parameter int W          = 1,
  parameter bit REGISTERED = 1'b1,
  parameter bit ASYNC_RST  = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] held;

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or posedge rst) begin
        if (rst)     held <= '0;
        else if (ce) held <= d;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (rst)     held <= '0;
        else if (ce) held <= d;
      end
    end
  endgenerate

  assign q = REGISTERED ? held : d;

endmodule

// File: rtl/acc54_ctrl.sv
// Aligns the sign flags and the load control with the operand stage
module acc54_ctrl
  import acc54_pkg::*;
#(
  parameter bit ASIGN_IN_REG = 1'b1,
  parameter bit BSIGN_IN_REG = 1'b1,
  parameter bit LOAD_IN_REG  = 1'b1,
  parameter int MODE         = 0,
  parameter bit ASYNC_RST    = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         aSigned,
  input  logic         bSigned,
  input  logic         accLoad,
  output ctrlStrobes_t strb
);

  localparam bit HAS_FEEDBACK = (MODE != 2);

  logic aSignQ;
  logic bSignQ;
  logic loadQ;

  acc54_stage #(.W(1), .REGISTERED(ASIGN_IN_REG), .ASYNC_RST(ASYNC_RST)) uASign (
    .clk(clk), .rst(rst), .ce(ce), .d(aSigned), .q(aSignQ)
  );

  acc54_stage #(.W(1), .REGISTERED(BSIGN_IN_REG), .ASYNC_RST(ASYNC_RST)) uBSign (
    .clk(clk), .rst(rst), .ce(ce), .d(bSigned), .q(bSignQ)
  );

  acc54_stage #(.W(1), .REGISTERED(LOAD_IN_REG), .ASYNC_RST(ASYNC_RST)) uLoad (
    .clk(clk), .rst(rst), .ce(ce), .d(accLoad), .q(loadQ)
  );

  always_comb begin
    strb.aSigned     = aSignQ;
    strb.bSigned     = bSignQ;
    strb.useFeedback = HAS_FEEDBACK && loadQ;
  end

endmodule

// File: rtl/acc54_datapath.sv
// Operand capture, extension, three-term adder and accumulator
module acc54_datapath
  import acc54_pkg::*;
#(
  parameter int W          = 54,
  parameter bit A_IN_REG   = 1'b1,
  parameter bit B_IN_REG   = 1'b1,
  parameter bit OUT_REG_EN = 1'b1,
  parameter bit B_SUB      = 1'b0,
  parameter bit SECOND_SUB = 1'b0,
  parameter int MODE       = 0,
  parameter bit ASYNC_RST  = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W:0]   casIn,
  input  ctrlStrobes_t strb,
  output logic [W:0]   sumOut
);

  localparam int CW = W + 1;

  logic [W-1:0]  aQ;
  logic [W-1:0]  bQ;
  logic [CW-1:0] extA;
  logic [CW-1:0] extB;
  logic [CW-1:0] termB;
  logic [CW-1:0] termA;
  logic [CW-1:0] fbTerm;
  logic [CW-1:0] sumNow;
  logic [CW-1:0] accQ;

  acc54_stage #(.W(W), .REGISTERED(A_IN_REG), .ASYNC_RST(ASYNC_RST)) uAReg (
    .clk(clk), .rst(rst), .ce(ce), .d(aIn), .q(aQ)
  );

  acc54_stage #(.W(W), .REGISTERED(B_IN_REG), .ASYNC_RST(ASYNC_RST)) uBReg (
    .clk(clk), .rst(rst), .ce(ce), .d(bIn), .q(bQ)
  );

  always_comb begin
    extA   = {strb.aSigned & aQ[W-1], aQ};
    extB   = {strb.bSigned & bQ[W-1], bQ};
    termB  = B_SUB ? (~extB + 1'b1) : extB;
    termA  = SECOND_SUB ? (~extA + 1'b1) : extA;
    fbTerm = strb.useFeedback ? accQ : '0;
    case (MODE)
      0:       sumNow = fbTerm + termB + termA;
      1:       sumNow = fbTerm + termB + casIn;
      default: sumNow = extA + termB + casIn;
    endcase
  end

  // Accumulator is always a register; OUT_REG_EN only picks what is shown
  acc54_stage #(.W(CW), .REGISTERED(1'b1), .ASYNC_RST(ASYNC_RST)) uAcc (
    .clk(clk), .rst(rst), .ce(ce), .d(sumNow), .q(accQ)
  );

  assign sumOut = OUT_REG_EN ? accQ : sumNow;

endmodule

// File: rtl/acc54_unit.sv
// Thin top: control strobes into the datapath
module acc54_unit
  import acc54_pkg::*;
#(
  parameter int W            = 54,
  parameter bit A_IN_REG     = 1'b1,
  parameter bit B_IN_REG     = 1'b1,
  parameter bit ASIGN_IN_REG = 1'b1,
  parameter bit BSIGN_IN_REG = 1'b1,
  parameter bit LOAD_IN_REG  = 1'b1,
  parameter bit OUT_REG_EN   = 1'b1,
  parameter bit B_SUB        = 1'b0,
  parameter bit SECOND_SUB   = 1'b0,
  parameter int MODE         = 0,
  parameter bit ASYNC_RST    = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W:0]   casIn,
  input  logic         aSigned,
  input  logic         bSigned,
  input  logic         accLoad,
  output logic [W-1:0] dout,
  output logic [W:0]   casOut
);

  ctrlStrobes_t strb;
  logic [W:0]   sumOut;

  acc54_ctrl #(
    .ASIGN_IN_REG(ASIGN_IN_REG), .BSIGN_IN_REG(BSIGN_IN_REG),
    .LOAD_IN_REG(LOAD_IN_REG), .MODE(MODE), .ASYNC_RST(ASYNC_RST)
  ) uCtrl (
    .clk(clk), .rst(rst), .ce(ce),
    .aSigned(aSigned), .bSigned(bSigned), .accLoad(accLoad),
    .strb(strb)
  );

  acc54_datapath #(
    .W(W), .A_IN_REG(A_IN_REG), .B_IN_REG(B_IN_REG), .OUT_REG_EN(OUT_REG_EN),
    .B_SUB(B_SUB), .SECOND_SUB(SECOND_SUB), .MODE(MODE), .ASYNC_RST(ASYNC_RST)
  ) uPath (
    .clk(clk), .rst(rst), .ce(ce),
    .aIn(aIn), .bIn(bIn), .casIn(casIn),
    .strb(strb), .sumOut(sumOut)
  );

  assign casOut = sumOut;
  assign dout   = sumOut[W-1:0];

endmodule

// File: rtl/acc54_unit_checker.sv
module acc54_unit_checker #(
  parameter int W            = 54,
  parameter bit A_IN_REG     = 1'b1,
  parameter bit B_IN_REG     = 1'b1,
  parameter bit ASIGN_IN_REG = 1'b1,
  parameter bit BSIGN_IN_REG = 1'b1,
  parameter bit LOAD_IN_REG  = 1'b1,
  parameter bit OUT_REG_EN   = 1'b1,
  parameter bit B_SUB        = 1'b0,
  parameter bit SECOND_SUB   = 1'b0,
  parameter int MODE         = 0
) (
  input logic         clk,
  input logic         rst,
  input logic         ce,
  input logic [W-1:0] aIn,
  input logic [W-1:0] bIn,
  input logic [W:0]   casIn,
  input logic         aSigned,
  input logic         bSigned,
  input logic         accLoad,
  input logic [W:0]   casOut
);

  localparam bit ALL_BYPASS = !A_IN_REG && !B_IN_REG && !ASIGN_IN_REG &&
                              !BSIGN_IN_REG && !LOAD_IN_REG;

  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  function automatic logic [W:0] expectSum(
    input logic [W:0] prev, input logic ld, input logic [W-1:0] a,
    input logic [W-1:0] b, input logic sa, input logic sb, input logic [W:0] c);
    logic [W:0] ea, eb, fb;
    ea = {sa & a[W-1], a};
    eb = {sb & b[W-1], b};
    fb = ld ? prev : '0;
    if (B_SUB) eb = -eb;
    case (MODE)
      0:       return fb + eb + (SECOND_SUB ? -ea : ea);
      1:       return fb + eb + c;
      default: return {sa & a[W-1], a} + eb + c;
    endcase
  endfunction

  // R1 clear after reset
  a_r1_reset_clears: assert property (@(posedge clk)
    (OUT_REG_EN && $past(rst)) |-> (casOut == '0));

  // R7 hold while enable low
  a_r7_hold_on_ce_low: assert property (@(posedge clk) disable iff (rst || !seen)
    (OUT_REG_EN && !$past(ce) && !$past(rst)) |-> $stable(casOut));

  generate
    if (ALL_BYPASS && OUT_REG_EN) begin : g_regsum
      // R2 / R3 / R4 / R5 recurrence for the selected mode
      a_r2_r3_r4_sum_step: assert property (@(posedge clk) disable iff (rst || !seen)
        ($past(ce) && !$past(rst)) |->
        (casOut == expectSum($past(casOut), $past(accLoad), $past(aIn), $past(bIn),
                             $past(aSigned), $past(bSigned), $past(casIn))));
    end
    if (ALL_BYPASS && !OUT_REG_EN && MODE == 2) begin : g_combsum
      // R4 / R8 combinational sum without feedback
      a_r4_comb_no_feedback: assert property (@(posedge clk) disable iff (rst)
        casOut == expectSum('0, 1'b0, aIn, bIn, aSigned, bSigned, casIn));
    end
  endgenerate

endmodule

bind acc54_unit acc54_unit_checker #(
  .W(W), .A_IN_REG(A_IN_REG), .B_IN_REG(B_IN_REG), .ASIGN_IN_REG(ASIGN_IN_REG),
  .BSIGN_IN_REG(BSIGN_IN_REG), .LOAD_IN_REG(LOAD_IN_REG), .OUT_REG_EN(OUT_REG_EN),
  .B_SUB(B_SUB), .SECOND_SUB(SECOND_SUB), .MODE(MODE)
) uChk (
  .clk(clk), .rst(rst), .ce(ce), .aIn(aIn), .bIn(bIn), .casIn(casIn),
  .aSigned(aSigned), .bSigned(bSigned), .accLoad(accLoad), .casOut(casOut)
);

// File: tb/tb_acc54_unit.sv
`timescale 1ns/1ps
module tb_acc54_unit;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b1;
  logic [53:0] a = '0, b = '0;
  logic [54:0] c = '0;
  logic sa = 1'b0, sb = 1'b0, ld = 1'b0;

  logic [53:0] d0, dS, d1, d2;
  logic [54:0] o0, oS, o1, o2;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // mode 0, everything registered, both terms added, sync reset
  acc54_unit dut (.clk(clk), .rst(rst), .ce(ce), .aIn(a), .bIn(b), .casIn(c),
    .aSigned(sa), .bSigned(sb), .accLoad(ld), .dout(d0), .casOut(o0));

  // mode 0, bypassed inputs, A subtracted
  acc54_unit #(.A_IN_REG(0), .B_IN_REG(0), .ASIGN_IN_REG(0), .BSIGN_IN_REG(0),
    .LOAD_IN_REG(0), .SECOND_SUB(1), .MODE(0)) dutM0s (
    .clk(clk), .rst(rst), .ce(ce), .aIn(a), .bIn(b), .casIn(c),
    .aSigned(sa), .bSigned(sb), .accLoad(ld), .dout(dS), .casOut(oS));

  // mode 1, bypassed inputs, B subtracted, async reset
  acc54_unit #(.A_IN_REG(0), .B_IN_REG(0), .ASIGN_IN_REG(0), .BSIGN_IN_REG(0),
    .LOAD_IN_REG(0), .B_SUB(1), .MODE(1), .ASYNC_RST(1)) dutM1 (
    .clk(clk), .rst(rst), .ce(ce), .aIn(a), .bIn(b), .casIn(c),
    .aSigned(sa), .bSigned(sb), .accLoad(ld), .dout(d1), .casOut(o1));

  // mode 2, fully combinational, B subtracted
  acc54_unit #(.A_IN_REG(0), .B_IN_REG(0), .ASIGN_IN_REG(0), .BSIGN_IN_REG(0),
    .LOAD_IN_REG(0), .OUT_REG_EN(0), .B_SUB(1), .MODE(2)) dutM2 (
    .clk(clk), .rst(rst), .ce(ce), .aIn(a), .bIn(b), .casIn(c),
    .aSigned(sa), .bSigned(sb), .accLoad(ld), .dout(d2), .casOut(o2));

  // bench-side expected state
  logic [54:0] m0Acc = '0, mSAcc = '0, m1Acc = '0;
  logic [53:0] rA = '0, rB = '0;
  logic rSa = 1'b0, rSb = 1'b0, rLd = 1'b0;

  function automatic logic [54:0] ex(input logic [53:0] x, input logic s);
    return {s & x[53], x};
  endfunction

  function automatic logic [53:0] rnd54();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[53:0];
  endfunction

  task automatic chk(input string tag, input logic [54:0] act, input logic [54:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic zeroModel();
    m0Acc = '0; mSAcc = '0; m1Acc = '0;
    rA = '0; rB = '0; rSa = 1'b0; rSb = 1'b0; rLd = 1'b0;
  endtask

  task automatic checkAll();
    chk("R2 mode0 registered", o0, m0Acc);
    chk("R10 slice dut", {1'b0, d0}, {1'b0, m0Acc[53:0]});
    chk("R2 mode0 subtract A", oS, mSAcc);
    chk("R3 mode1", o1, m1Acc);
    chk("R10 slice M1", {1'b0, d1}, {1'b0, m1Acc[53:0]});
  endtask

  task automatic step(input logic [53:0] ia, input logic [53:0] ib, input logic [54:0] ic,
                      input logic isa, input logic isb, input logic ild, input logic ien);
    @(negedge clk);
    a = ia; b = ib; c = ic; sa = isa; sb = isb; ld = ild; ce = ien;
    #1;
    chk("R4 mode2 comb", o2, ex(ia, isa) - ex(ib, isb) + ic);
    chk("R10 slice M2", {1'b0, d2}, {1'b0, o2[53:0]});
    @(posedge clk);
    if (ien) begin
      m0Acc = (rLd ? m0Acc : 55'd0) + ex(rB, rSb) + ex(rA, rSa);
      rA = ia; rB = ib; rSa = isa; rSb = isb; rLd = ild;
      mSAcc = (ild ? mSAcc : 55'd0) + ex(ib, isb) - ex(ia, isa);
      m1Acc = (ild ? m1Acc : 55'd0) - ex(ib, isb) + ic;
    end
    #1;
    checkAll();
  endtask

  task automatic syncReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    zeroModel();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [54:0] hold0;
    void'($urandom(32'd5150));
    syncReset();
    #1;
    // R1 reset state
    chk("R1 reset dut", o0, '0);
    chk("R1 reset M0s", oS, '0);
    chk("R1 reset M1", o1, '0);

    // R8 latency: registered inputs take one extra edge
    step(54'd7, 54'd0, 55'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 registered not yet visible", o0, 55'd0);
    chk("R8 bypass visible after one edge", oS, -55'd7);
    step(54'd0, 54'd0, 55'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 registered visible after two edges", o0, 55'd7);

    // R5 fresh sum then accumulate (mode 1: F - B + cas)
    step(54'd5, 54'd5, 55'd100, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 fresh sum", o1, 55'd95);
    step(54'd1, 54'd3, 55'd10, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5 accumulate", o1, 55'd102);
    step(54'd1, 54'd2, 55'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 load low restarts", o1, -55'd1);

    // R6 extension of an all-ones operand (mode 2 comb)
    @(negedge clk);
    a = '1; b = '0; c = '0; sa = 1'b1; sb = 1'b0; ld = 1'b0; ce = 1'b0;
    #1;
    chk("R6 sign extend", o2, {55{1'b1}});
    sa = 1'b0;
    #1;
    chk("R6 zero extend", o2, {1'b0, {54{1'b1}}});
    // R4 load has no effect in mode 2
    ld = 1'b1;
    #1;
    chk("R4 load ignored", o2, {1'b0, {54{1'b1}}});

    // R7 enable low holds all registers
    step(54'd9, 54'd4, 55'd3, 1'b0, 1'b0, 1'b1, 1'b1);
    hold0 = o0;
    step(54'd123, 54'd77, 55'd55, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R7 hold dut", o0, hold0);
    step(54'd0, 54'd0, 55'd0, 1'b0, 1'b0, 1'b1, 1'b1);

    // R10 wrap with unsigned maximum operands
    syncReset();
    step('1, '1, '1, 1'b0, 1'b0, 1'b0, 1'b1);
    step('1, '1, '1, 1'b0, 1'b0, 1'b1, 1'b1);
    step('0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b1);

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [53:0] ra, rb;
      logic [54:0] rc;
      ra = rnd54(); rb = rnd54();
      rc = {$urandom_range(1, 0) == 1 ? 1'b1 : 1'b0, rnd54()};
      if ($urandom_range(9, 0) == 0) ra = '1;
      if ($urandom_range(9, 0) == 0) rb = {1'b0, {53{1'b1}}};
      step(ra, rb, rc, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
           ($urandom_range(3, 0) != 0), ($urandom_range(4, 0) != 0));
    end

    // R9 async clear between edges, sync unit keeps its value
    step(54'd40, 54'd1, 55'd50, 1'b0, 1'b0, 1'b0, 1'b1);
    step(54'd0, 54'd0, 55'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    ce = 1'b1;
    rst = 1'b1;
    #1;
    chk("R9 async clears at once", o1, '0);
    chk("R9 sync waits for edge", o0, m0Acc);
    @(posedge clk);
    zeroModel();
    #1;
    chk("R9 sync cleared at edge", o0, '0);
    chk("R1 cleared M0s", oS, '0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule